// File: doc/BRIEF.md
# Priority Queue to Port Transmit Scheduler

This block decides which cell goes out next on a multi-PHY transmit cell interface. Cell queues come in groups of four, and each group serves one pair of ports, one even and one odd. Within a group the queue index sets a fixed priority: the lowest index is the most urgent. A routing vector holds one bit per queue and sends that queue to either the even port or the odd port of its pair. A mode input selects between 32-port operation, which uses every queue, and 16-port operation, which uses only the lower half of the ports and queues.

The ports all have the same standing on the bus. A round-robin search starts one port past the last port granted and considers only ports that are ready and have at least one waiting queue routed to them. The selected port takes its cell from its most urgent waiting queue. The search runs all the time while the current cell is moving. A transfer-done strobe registers the result, so a fresh grant is available in the cycle after the strobe, with no idle arbitration cycles. Software loads the routing vector in 16-bit words.

Top module: `cell_port_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_valid` is 0. The round-robin pointer resets so that the first search begins at port 0.
- R2: Grant outputs change only on the clock edge where `xfer_done` is 1. Between strobes they hold their values, even when the inputs change.
- R3: A valid grant names a queue that was waiting, and a port that was ready, in the cycle the strobe was sampled. The queue lies in that port's group, which is queue index / 4 = port index / 2.
- R4: Among the waiting queues routed to the chosen port, the grant goes to the one with the lowest index inside the group (priority 0 is the most urgent).
- R5: A queue whose routing bit is 0 serves the even port of its pair. A queue whose routing bit is 1 serves the odd port.
- R6: After reset the routing bit of every queue equals bit 0 of its index. Priorities 0 and 2 therefore go to the even port, and priorities 1 and 3 go to the odd port.
- R7: When `route_wr_en` is 1, `route_wr_data` replaces routing bits [16*s+15 : 16*s], where s = `route_wr_sel`. Word 3 covers bits 63:48 and word 0 covers bits 15:0.
- R8: When `mode_32p` is 0, only ports 0 to 15 and queues 0 to 31 can be granted. Waiting flags of queues 32 to 63 have no effect.
- R9: The search starts at the port after the last port granted, wrapping from 31 to 0. The first eligible port found wins.
- R10: A port whose `port_ready` bit is 0 is skipped, whatever its queues hold.
- R11: When no port is eligible at a strobe, `grant_valid` goes to 0 and the round-robin pointer stays where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_32p | input | 1 | 1: 32 ports and 64 queues; 0: 16 ports and 32 queues |
| q_waiting | input | 64 | One flag per queue, set when the queue holds a cell |
| port_ready | input | 32 | One flag per port, set when the port can accept a cell |
| route_wr_en | input | 1 | Write strobe for one routing word |
| route_wr_sel | input | 2 | Routing word index (0 = bits 15:0 to 3 = bits 63:48) |
| route_wr_data | input | 16 | Routing word value |
| xfer_done | input | 1 | Current cell transfer finishing; latch the next grant |
| grant_valid | output | 1 | The grant below is valid |
| grant_port | output | 5 | Port granted |
| grant_queue | output | 6 | Queue that supplies the cell |

## Verification
The checker compares each grant against copies of `q_waiting`, `port_ready`, the mode bit and the routing vector taken at the strobe edge. It therefore assumes these inputs are stable around that edge and are free of unknown values once reset is released. The bench changes every input on the falling clock edge and keeps each strobe to a single cycle. It also never writes a routing word in the same cycle as a strobe, so every check has one clearly defined set of inputs.

// File: rtl/cps_pkg.sv
package cps_pkg;

   // Lowest set bit of a small request vector; lower index is more urgent.
   function automatic int lowest_set(input logic [15:0] req, input int width);
      int idx;
      idx = -1;
      for (int k = width - 1; k >= 0; k--) begin
         if (req[k]) idx = k;
      end
      return idx;
   endfunction

endpackage

// File: rtl/cps_route_regs.sv
module cps_route_regs #(
   parameter int NUM_QUEUES = 64,
   parameter int WORD_W     = 16,
   localparam int NUM_WORDS = NUM_QUEUES / WORD_W,
   localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [WORD_W-1:0]     wr_data,
   output logic [NUM_QUEUES-1:0] route_bits
);

   for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_bit
      localparam int WIDX = q / WORD_W;
      localparam int BIDX = q % WORD_W;
      localparam logic DEF = 1'(q % 2);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_bits[q] <= DEF;
         end else if (wr_en && (int'(wr_sel) == WIDX)) begin
            route_bits[q] <= wr_data[BIDX];
         end
      end
   end

endmodule

// File: rtl/cps_port_req.sv
module cps_port_req #(
   parameter int NUM_QUEUES = 64,
   parameter int QPG        = 4,
   localparam int NUM_GRP   = NUM_QUEUES / QPG,
   localparam int NUM_PORTS = 2 * NUM_GRP,
   localparam int QW        = $clog2(NUM_QUEUES)
) (
   input  logic                  mode_32p,
   input  logic [NUM_QUEUES-1:0] q_waiting,
   input  logic [NUM_QUEUES-1:0] route_bits,
   input  logic [NUM_PORTS-1:0]  port_ready,
   output logic [NUM_PORTS-1:0]  port_req,
   output logic [QW-1:0]         port_q [NUM_PORTS]
);
   import cps_pkg::*;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int GRP   = p / 2;
      localparam int BASE  = GRP * QPG;
      localparam logic ODD = 1'(p % 2);
      localparam bit UPPER = (p >= NUM_PORTS / 2);

      logic [QPG-1:0] routed;
      logic [15:0]    cand;
      logic           enabled;
      int             pick;

      always_comb begin
         for (int k = 0; k < QPG; k++) begin
            routed[k] = q_waiting[BASE + k] && (route_bits[BASE + k] == ODD);
         end
         cand    = 16'(routed);
         enabled = mode_32p || !UPPER;
         pick    = lowest_set(cand, QPG);
         port_req[p] = enabled && port_ready[p] && (pick >= 0);
         port_q[p]   = (pick >= 0) ? QW'(BASE + pick) : QW'(BASE);
      end
   end

endmodule

// File: rtl/cps_rr_pick.sv
module cps_rr_pick #(
   parameter int N   = 32,
   localparam int PW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] last,
   output logic          found,
   output logic [PW-1:0] pick
);

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = 1; i <= N; i++) begin
         automatic int c = (int'(last) + i) % N;
         if (!found && req[c]) begin
            found = 1'b1;
            pick  = PW'(c);
         end
      end
   end

endmodule

// File: rtl/cell_port_sched.sv
module cell_port_sched #(
   parameter int NUM_QUEUES   = 64,
   parameter int QPG          = 4,
   parameter int ROUTE_WORD_W = 16,
   localparam int NUM_GRP     = NUM_QUEUES / QPG,
   localparam int NUM_PORTS   = 2 * NUM_GRP,
   localparam int PW          = $clog2(NUM_PORTS),
   localparam int QW          = $clog2(NUM_QUEUES),
   localparam int NUM_WORDS   = NUM_QUEUES / ROUTE_WORD_W,
   localparam int SEL_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_32p,
   input  logic [NUM_QUEUES-1:0]   q_waiting,
   input  logic [NUM_PORTS-1:0]    port_ready,
   input  logic                    route_wr_en,
   input  logic [SEL_W-1:0]        route_wr_sel,
   input  logic [ROUTE_WORD_W-1:0] route_wr_data,
   input  logic                    xfer_done,
   output logic                    grant_valid,
   output logic [PW-1:0]           grant_port,
   output logic [QW-1:0]           grant_queue
);

   if (QPG < 2 || (QPG & (QPG - 1)) != 0 || QPG > 16) begin : g_bad_qpg
      $error("QPG must be a power of two from 2 to 16");
   end
   if (NUM_QUEUES % QPG != 0) begin : g_bad_nq
      $error("NUM_QUEUES must be a multiple of QPG");
   end
   if (NUM_QUEUES % ROUTE_WORD_W != 0) begin : g_bad_word
      $error("NUM_QUEUES must be a multiple of ROUTE_WORD_W");
   end
   if ((NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
      $error("port count must be a power of two");
   end

   logic [NUM_QUEUES-1:0] route_bits;
   logic [NUM_PORTS-1:0]  port_req;
   logic [QW-1:0]         port_q [NUM_PORTS];
   logic                  rr_found;
   logic [PW-1:0]         rr_pick;
   logic [PW-1:0]         rr_last;

   cps_route_regs #(
      .NUM_QUEUES (NUM_QUEUES),
      .WORD_W     (ROUTE_WORD_W)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (route_wr_en),
      .wr_sel     (route_wr_sel),
      .wr_data    (route_wr_data),
      .route_bits (route_bits)
   );

   cps_port_req #(
      .NUM_QUEUES (NUM_QUEUES),
      .QPG        (QPG)
   ) u_req (
      .mode_32p   (mode_32p),
      .q_waiting  (q_waiting),
      .route_bits (route_bits),
      .port_ready (port_ready),
      .port_req   (port_req),
      .port_q     (port_q)
   );

   cps_rr_pick #(
      .N     (NUM_PORTS)
   ) u_rr (
      .req   (port_req),
      .last  (rr_last),
      .found (rr_found),
      .pick  (rr_pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_port  <= '0;
         grant_queue <= '0;
         rr_last     <= PW'(NUM_PORTS - 1);
      end else if (xfer_done) begin
         grant_valid <= rr_found;
         if (rr_found) begin
            grant_port  <= rr_pick;
            grant_queue <= port_q[rr_pick];
            rr_last     <= rr_pick;
         end
      end
   end

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int NUM_QUEUES = 64,
   parameter int QPG        = 4,
   localparam int NUM_PORTS = 2 * (NUM_QUEUES / QPG),
   localparam int PW        = $clog2(NUM_PORTS),
   localparam int QW        = $clog2(NUM_QUEUES),
   localparam int KW        = $clog2(QPG)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mode_32p,
   input logic [NUM_QUEUES-1:0] q_waiting,
   input logic [NUM_PORTS-1:0]  port_ready,
   input logic [NUM_QUEUES-1:0] route_bits,
   input logic                  xfer_done,
   input logic                  grant_valid,
   input logic [PW-1:0]         grant_port,
   input logic [QW-1:0]         grant_queue
);

   logic [NUM_QUEUES-1:0] wait_d;
   logic [NUM_QUEUES-1:0] route_d;
   logic [NUM_PORTS-1:0]  ready_d;
   logic                  mode_d;
   logic                  upd_d;
   logic                  better;
   int                    base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_d  <= '0;
         route_d <= '0;
         ready_d <= '0;
         mode_d  <= 1'b0;
         upd_d   <= 1'b0;
      end else begin
         wait_d  <= q_waiting;
         route_d <= route_bits;
         ready_d <= port_ready;
         mode_d  <= mode_32p;
         upd_d   <= xfer_done;
      end
   end

   always_comb begin
      base   = int'(grant_queue) - int'(grant_queue[KW-1:0]);
      better = 1'b0;
      for (int k = 0; k < QPG; k++) begin
         if (k < int'(grant_queue[KW-1:0]) && wait_d[base + k]
             && (route_d[base + k] == grant_port[0])) begin
            better = 1'b1;
         end
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !grant_valid);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_done |=> $stable({grant_valid, grant_port, grant_queue}));

   p_waiting_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_d && grant_valid) |-> (wait_d[grant_queue] && ready_d[grant_port]));

   p_same_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (grant_queue[QW-1:KW] == grant_port[PW-1:1]));

   p_top_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_d && grant_valid) |-> !better);

   p_route_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_d && grant_valid) |-> (route_d[grant_queue] == grant_port[0]));

   p_half_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_d && grant_valid && !mode_d) |-> !grant_port[PW-1]);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_d && (wait_d == '0)) |-> !grant_valid);

endmodule

bind cell_port_sched cps_checker #(
   .NUM_QUEUES (NUM_QUEUES),
   .QPG        (QPG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_32p    (mode_32p),
   .q_waiting   (q_waiting),
   .port_ready  (port_ready),
   .route_bits  (route_bits),
   .xfer_done   (xfer_done),
   .grant_valid (grant_valid),
   .grant_port  (grant_port),
   .grant_queue (grant_queue)
);

// File: tb/cell_port_sched_bench.sv
module cell_port_sched_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_32p = 1'b1;
   logic [63:0] q_waiting = '0;
   logic [31:0] port_ready = '1;
   logic        route_wr_en = 1'b0;
   logic [1:0]  route_wr_sel = '0;
   logic [15:0] route_wr_data = '0;
   logic        xfer_done = 1'b0;
   logic        grant_valid;
   logic [4:0]  grant_port;
   logic [5:0]  grant_queue;

   int n_tests = 0;
   int n_fail  = 0;

   logic [63:0] route_m;
   int          last_m;
   logic        exp_valid;
   logic [4:0]  exp_port;
   logic [5:0]  exp_queue;

   always #4 clk = ~clk;

   cell_port_sched u_cell_port_sched (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_32p      (mode_32p),
      .q_waiting     (q_waiting),
      .port_ready    (port_ready),
      .route_wr_en   (route_wr_en),
      .route_wr_sel  (route_wr_sel),
      .route_wr_data (route_wr_data),
      .xfer_done     (xfer_done),
      .grant_valid   (grant_valid),
      .grant_port    (grant_port),
      .grant_queue   (grant_queue)
   );

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   task automatic check_grant(string req);
      logic ok;
      n_tests++;
      ok = (grant_valid === exp_valid) &&
           (!exp_valid || (grant_port === exp_port && grant_queue === exp_queue));
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b port=%0d queue=%0d, expected valid=%0b port=%0d queue=%0d",
                  req, grant_valid, grant_port, grant_queue, exp_valid, exp_port, exp_queue);
      end
   endtask

   // Reference choice computed from the requirements.
   task automatic model_pick();
      exp_valid = 1'b0;
      for (int i = 1; i <= 32; i++) begin
         automatic int p = (last_m + i) % 32;
         if (!exp_valid && (mode_32p || p < 16) && port_ready[p]) begin
            for (int k = 0; k < 4; k++) begin
               automatic int q = (p / 2) * 4 + k;
               if (!exp_valid && q_waiting[q] && (route_m[q] == 1'(p % 2))) begin
                  exp_valid = 1'b1;
                  exp_port  = 5'(p);
                  exp_queue = 6'(q);
               end
            end
         end
      end
      if (exp_valid) last_m = int'(exp_port);
   endtask

   task automatic pulse();
      model_pick();
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic wr_route(input logic [1:0] sel, input logic [15:0] data);
      route_wr_en   = 1'b1;
      route_wr_sel  = sel;
      route_wr_data = data;
      @(negedge clk);
      route_wr_en = 1'b0;
      route_m[int'(sel)*16 +: 16] = data;
   endtask

   task automatic t_reset();
      exp_valid = 1'b0;
      check_grant("R1 reset idle");
      @(negedge clk);
      check_grant("R1 idle after reset");
   endtask

   task automatic t_default_route();
      q_waiting = 64'h0000_0000_0000_F000;   // group 3, all four queues
      pulse();
      exp_port = 5'd6; exp_queue = 6'd12;
      check_grant("R6 even port gets priority 0");
      pulse();
      exp_port = 5'd7; exp_queue = 6'd13;
      check_grant("R6 odd port gets priority 1");
      q_waiting = 64'h0000_0000_0000_0004;   // queue 2, even side
      pulse();
      check_grant("R6 priority 2 on even port, R9 wrap from last grant");
   endtask

   task automatic t_priority();
      q_waiting = 64'h0000_0000_00A0_0000;   // queues 21 and 23, odd side
      pulse();
      exp_port = 5'd11; exp_queue = 6'd21;
      check_grant("R4 lowest index wins in group");
      q_waiting = 64'h0000_0000_0000_0500;   // queues 8 and 10, even side
      pulse();
      check_grant("R4 R3 queue 8 over queue 10");
   endtask

   task automatic t_route_write();
      wr_route(2'd1, 16'h0000);              // queues 16..31 to even ports
      q_waiting = 64'h0000_0000_0002_0000;   // queue 17
      pulse();
      exp_port = 5'd8; exp_queue = 6'd17;
      check_grant("R7 R5 word 1 write moves queue 17 to even port");
      wr_route(2'd3, 16'hFFFF);              // queues 48..63 to odd ports
      q_waiting = 64'h0001_0000_0000_0000;   // queue 48
      pulse();
      exp_port = 5'd25; exp_queue = 6'd48;
      check_grant("R7 R5 word 3 write moves queue 48 to odd port");
      wr_route(2'd1, 16'hAAAA);
      wr_route(2'd3, 16'hAAAA);
   endtask

   task automatic t_half_mode();
      mode_32p  = 1'b0;
      q_waiting = 64'h0000_0100_0000_0000;   // queue 40 -> port 20
      pulse();
      check_grant("R8 upper queue ignored in 16-port mode");
      q_waiting = 64'hFFFF_FFFF_0000_0020;   // upper half plus queue 5
      pulse();
      exp_port = 5'd3; exp_queue = 6'd5;
      check_grant("R8 only lower ports granted");
      mode_32p = 1'b1;
   endtask

   task automatic t_round_robin();
      q_waiting = '1;
      for (int i = 0; i < 6; i++) begin
         automatic int prev = last_m;
         pulse();
         check_grant("R9 rotation");
         n_tests++;
         if (int'(grant_port) != (prev + 1) % 32) begin
            n_fail++;
            $display("FAIL R9 next port: got %0d expected %0d", grant_port, (prev + 1) % 32);
         end
      end
   endtask

   task automatic t_ready();
      port_ready = 32'h0000_0010;
      q_waiting  = '1;
      pulse();
      exp_port = 5'd4; exp_queue = 6'd8;
      check_grant("R10 only ready port granted");
      port_ready = 32'h0000_0000;
      pulse();
      check_grant("R10 no ready port gives no grant");
      port_ready = '1;
   endtask

   task automatic t_idle_pointer();
      automatic int held;
      q_waiting = '1;
      pulse();
      held = last_m;
      q_waiting = '0;
      pulse();
      check_grant("R11 idle strobe");
      q_waiting = '1;
      pulse();
      exp_port = 5'((held + 1) % 32);
      check_grant("R11 pointer kept across idle strobe");
   endtask

   task automatic t_hold();
      q_waiting = 64'h0000_0000_0000_0002;   // queue 1 -> port 1
      pulse();
      check_grant("R2 grant after strobe");
      q_waiting = '1;
      port_ready = 32'h0000_0000;
      repeat (3) @(negedge clk);
      check_grant("R2 grant held without strobe");
      port_ready = '1;
   endtask

   initial begin
      route_m = 64'hAAAA_AAAA_AAAA_AAAA;
      last_m  = 31;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      exp_valid = 1'b0;
      check_grant("R1 first cycle out of reset");
      t_default_route();
      t_priority();
      t_route_write();
      t_half_mode();
      t_round_robin();
      t_ready();
      t_idle_pointer();
      t_hold();
      summary();
   end

endmodule